// File: doc/BRIEF.md
# SDRAM Burst Command Sequencer

This block serves a bus that issues one memory request at a time and turns each request into the SDRAM command stream for a single chip select. A request carries a byte address, a read/write flag, a transfer size and the width of the memory port. The sequencer opens the row, waits out the row-to-column delay, and issues one column command per data beat. It then either closes the page with a precharge-all or leaves it open for the next request.

A configuration input selects between two page policies. In burst page mode every access ends with a precharge. In continuous page mode the row stays open only if, on the cycle of the last column command, a new request is already waiting and its row matches the open row. That request is accepted on the same cycle and continues directly with column commands. In every other case the page is closed at once. The three delay counts (row-to-column, write recovery, precharge recovery) are parameters.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, and whenever no access is in progress, the chip is deselected: {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'b1111, sd_a = 0, sd_dqm = 4'b1111, and req_ready is high.
- R2: Command codes on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} are NOP 4'b0111, row activate 4'b0011, READ 4'b0101, WRITE 4'b0100 and precharge-all 4'b0010.
- R3: The cycle after a request is accepted from idle, the block issues row activate with sd_a = req_addr[ROW_W+COL_W-1:COL_W], followed by RCD_NOPS NOP cycles (none when RCD_NOPS is 0).
- R4: The number of column commands equals the transfer bytes divided by the port bytes, with a minimum of one. Size codes 0/1/2/3 mean 1/2/4/16 bytes. Port codes 0/1/2/3 mean 32/8/16/32-bit. The column commands run on consecutive cycles with sd_a = req_addr[COL_W-1:0] + beat index.
- R5: sd_dqm is 4'b0000 on every column command and 4'b1111 on every other cycle.
- R6: After the last WRITE of a closing access, WR_NOPS NOP cycles come before the precharge-all. After the last READ, the precharge-all follows directly.
- R7: Precharge-all drives sd_a with only bit 10 set. It is followed by RP_NOPS NOP cycles and then one idle cycle.
- R8: In continuous page mode (cfg_cont_page = 1), a request that is valid on the last column cycle and targets the open row is accepted on that cycle. Its column commands start on the next cycle, with no activate and no precharge in between.
- R9: In continuous page mode, a request whose row differs from the open row closes the page with the normal precharge sequence and then starts with its own activate.
- R10: In burst page mode (cfg_cont_page = 0), the page is closed after every access, even when a same-row request is waiting.
- R11: req_ready is low on every cycle of an access except the last column cycle of a continuous-mode page hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cont_page | input | 1 | 1 = continuous page mode, 0 = burst page mode |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ROW_W+COL_W | Address: row in the upper field, column in the lower field |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer size code (1/2/4/16 bytes) |
| req_port | input | 2 | Port width code (32/8/16/32-bit) |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_a | output | ROW_W | Multiplexed row/column address |
| sd_dqm | output | 4 | Byte masks, high = masked |

## Verification
Single reads and writes are driven with size and port combinations that give 1, 2 and 16 beats. These separate a wrong beat count from a wrong column step and show whether write recovery is applied only to writes. A second request is then raised while a first access is running, in three variants: same row in continuous mode, different row in continuous mode, and same row in burst mode. Only the first of these may skip the precharge and activate, so a wrong hit comparison or a policy that ignores the mode shows up as a different command stream. The ready output is compared on every cycle of every stream.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int ROW_W    = 12,
  parameter int COL_W    = 8,
  parameter int RCD_NOPS = 1,
  parameter int WR_NOPS  = 1,
  parameter int RP_NOPS  = 2,
  parameter int AP_BIT   = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_cont_page,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_write,
  input  logic [1:0]             req_size,
  input  logic [1:0]             req_port,
  output logic                   sd_cs_n,
  output logic                   sd_ras_n,
  output logic                   sd_cas_n,
  output logic                   sd_we_n,
  output logic [ROW_W-1:0]       sd_a,
  output logic [3:0]             sd_dqm
);
  localparam int AW = ROW_W + COL_W;
  localparam int CW = 8;

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_RCD, S_COL, S_WRR, S_PRE, S_RP} st_t;

  st_t              st;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [4:0]       nbeat_q, beat_q;
  logic [CW-1:0]    cnt;

  function automatic logic [4:0] beats_of(input logic [1:0] size, input logic [1:0] port);
    logic [2:0] sl, pl;
    sl = (size == 2'd3) ? 3'd4 : {1'b0, size};
    pl = (port == 2'd1) ? 3'd0 : (port == 2'd2) ? 3'd1 : 3'd2;
    return (sl > pl) ? 5'(1 << (sl - pl)) : 5'd1;
  endfunction

  wire [ROW_W-1:0] req_row   = req_addr[AW-1:COL_W];
  wire             last_beat = (st == S_COL) && (beat_q == nbeat_q - 5'd1);
  wire             hit_go    = last_beat && cfg_cont_page && req_valid && (req_row == row_q);
  assign req_ready = (st == S_IDLE) || hit_go;
  wire             take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; row_q <= '0; col_q <= '0; wr_q <= 1'b0;
      nbeat_q <= 5'd1; beat_q <= '0; cnt <= '0;
    end else begin
      if (take) begin
        row_q   <= req_row;
        col_q   <= req_addr[COL_W-1:0];
        wr_q    <= req_write;
        nbeat_q <= beats_of(req_size, req_port);
        beat_q  <= '0;
      end
      case (st)
        S_IDLE: if (take) st <= S_ACT;
        S_ACT:
          if (RCD_NOPS > 0) begin st <= S_RCD; cnt <= CW'(RCD_NOPS - 1); end
          else st <= S_COL;
        S_RCD: if (cnt == '0) st <= S_COL; else cnt <= cnt - 1'b1;
        S_COL:
          if (!last_beat) beat_q <= beat_q + 5'd1;
          else if (!hit_go) begin
            if (wr_q && WR_NOPS > 0) begin st <= S_WRR; cnt <= CW'(WR_NOPS - 1); end
            else st <= S_PRE;
          end
        S_WRR: if (cnt == '0) st <= S_PRE; else cnt <= cnt - 1'b1;
        S_PRE:
          if (RP_NOPS > 0) begin st <= S_RP; cnt <= CW'(RP_NOPS - 1); end
          else st <= S_IDLE;
        S_RP: if (cnt == '0) st <= S_IDLE; else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'b0111;
    sd_a   = '0;
    sd_dqm = 4'b1111;
    case (st)
      S_IDLE: {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'b1111;
      S_ACT: begin
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'b0011;
        sd_a = row_q;
      end
      S_COL: begin
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = wr_q ? 4'b0100 : 4'b0101;
        sd_a   = ROW_W'(COL_W'(col_q + COL_W'(beat_q)));
        sd_dqm = 4'b0000;
      end
      S_PRE: begin
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'b0010;
        sd_a[AP_BIT] = 1'b1;
      end
      default: ;
    endcase
  end

  wire is_nop  = !sd_cs_n &&  sd_ras_n &&  sd_cas_n &&  sd_we_n;
  wire is_act  = !sd_cs_n && !sd_ras_n &&  sd_cas_n &&  sd_we_n;
  wire is_col  = !sd_cs_n &&  sd_ras_n && !sd_cas_n;
  wire is_wr   = is_col && !sd_we_n;
  wire is_pall = !sd_cs_n && !sd_ras_n &&  sd_cas_n && !sd_we_n;

  if (RCD_NOPS > 0) begin : g_rcd
    p_act_then_nop_r3: assert property (@(posedge clk) disable iff (!rst_n) is_act |=> is_nop);
  end else begin : g_no_rcd
    p_act_then_col_r3: assert property (@(posedge clk) disable iff (!rst_n) is_act |=> is_col);
  end

  if (WR_NOPS > 0) begin : g_wr
    p_wr_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n) is_pall |-> !$past(is_wr));
  end

  if (RP_NOPS > 0) begin : g_rp
    p_pall_then_nop_r7: assert property (@(posedge clk) disable iff (!rst_n) is_pall |=> is_nop);
  end

  p_hit_keeps_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && is_col) |=> is_col);

  p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act || is_pall || is_nop) |-> !req_ready);
endmodule

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;
  localparam int ROW_W = 12, COL_W = 8, RCD = 1, WRN = 1, RPN = 2;
  localparam logic [3:0] C_IDLE = 4'b1111, C_NOP = 4'b0111, C_ACT = 4'b0011,
                         C_RD = 4'b0101, C_WR = 4'b0100, C_PALL = 4'b0010;

  logic clk = 0, rst_n = 0, cfg_cont_page = 0, req_valid = 0, req_write = 0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [1:0] req_size = 0, req_port = 0;
  logic req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [ROW_W-1:0] sd_a;
  logic [3:0] sd_dqm;

  int errors = 0, checks = 0;

  sdram_burst_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .RCD_NOPS(RCD), .WR_NOPS(WRN),
    .RP_NOPS(RPN), .AP_BIT(10)) i_sdram_burst_seq (
    .clk, .rst_n, .cfg_cont_page, .req_valid, .req_ready, .req_addr, .req_write,
    .req_size, .req_port, .sd_cs_n, .sd_ras_n, .sd_cas_n, .sd_we_n, .sd_a, .sd_dqm);

  always #4 clk = ~clk;

  logic [3:0]       e_cmd [128];
  logic [ROW_W-1:0] e_a   [128];
  logic             e_col [128];
  logic             e_rdy [128];
  string            e_tag [128];
  int n_exp = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [ROW_W-1:0] a, input bit col,
                      input bit rdy, input string tag);
    e_cmd[n_exp] = c; e_a[n_exp] = a; e_col[n_exp] = col; e_rdy[n_exp] = rdy; e_tag[n_exp] = tag;
    n_exp++;
  endtask

  function automatic int nbeats(input logic [1:0] sz, input logic [1:0] pt);
    int bytes, pb;
    case (sz) 2'd0: bytes = 1; 2'd1: bytes = 2; 2'd2: bytes = 4; default: bytes = 16; endcase
    case (pt) 2'd1: pb = 1; 2'd2: pb = 2; default: pb = 4; endcase
    return (bytes / pb < 1) ? 1 : bytes / pb;
  endfunction

  task automatic add_cols(input logic [COL_W-1:0] col, input bit wr, input int nb,
                          input bit last_rdy, input string tag);
    for (int i = 0; i < nb; i++)
      push(wr ? C_WR : C_RD, ROW_W'(COL_W'(col + i)), 1, (i == nb - 1) && last_rdy, tag);
  endtask

  task automatic add_open(input logic [ROW_W-1:0] row, input string tag);
    push(C_ACT, row, 0, 0, tag);
    for (int i = 0; i < RCD; i++) push(C_NOP, '0, 0, 0, "R3");
  endtask

  task automatic add_close(input bit wr, input string tag);
    if (wr) for (int i = 0; i < WRN; i++) push(C_NOP, '0, 0, 0, "R6");
    push(C_PALL, ROW_W'(1 << 10), 0, 0, tag);
    for (int i = 0; i < RPN; i++) push(C_NOP, '0, 0, 0, "R7");
    push(C_IDLE, '0, 0, 1, "R1");
  endtask

  // Drives the first request, optionally raises a second one on the cycle of the
  // activate, then compares every expected cycle.
  task automatic run(input logic [19:0] a1, input bit w1, input logic [1:0] s1, input logic [1:0] p1,
                     input bit two, input logic [19:0] a2, input bit w2,
                     input logic [1:0] s2, input logic [1:0] p2);
    bit pend = 0, drop = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a1; req_write = w1; req_size = s1; req_port = p1;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < n_exp; i++) begin
      if (i > 0) @(negedge clk);
      if (drop) begin req_valid = 0; drop = 0; end
      #1;
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == e_cmd[i] && sd_a == e_a[i],
            e_tag[i], $sformatf("cycle %0d cmd/addr", i),
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, 16'h0, sd_a}, {e_cmd[i], 16'h0, e_a[i]});
      check(sd_dqm == (e_col[i] ? 4'b0000 : 4'b1111), "R5", $sformatf("cycle %0d dqm", i),
            sd_dqm, e_col[i] ? 4'b0000 : 4'b1111);
      check(req_ready == e_rdy[i], "R11", $sformatf("cycle %0d ready", i), req_ready, e_rdy[i]);
      if (pend && req_ready) begin drop = 1; pend = 0; end
      if (i == 0 && two) begin
        req_valid = 1; req_addr = a2; req_write = w2; req_size = s2; req_port = p2; pend = 1;
      end
    end
    req_valid = 0;
    n_exp = 0;
  endtask

  task automatic t_reset;
    #1;
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_IDLE, "R1", "reset cmd",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_IDLE);
    check(sd_dqm == 4'b1111 && sd_a == '0, "R1", "reset dqm/addr", {sd_dqm, sd_a}, {4'hf, 12'h0});
    check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
  endtask

  task automatic t_single(input logic [19:0] a, input bit w, input logic [1:0] s, input logic [1:0] p);
    add_open(a[19:8], "R3");
    add_cols(a[7:0], w, nbeats(s, p), 0, "R4 (R2)");
    add_close(w, "R7 (R2)");
    run(a, w, s, p, 0, '0, 0, 0, 0);
  endtask

  task automatic t_cont_hit;
    cfg_cont_page = 1;
    add_open(12'h2a5, "R3");
    add_cols(8'h40, 0, nbeats(2'd3, 2'd0), 1, "R4 (R2)");
    add_cols(8'h90, 1, nbeats(2'd2, 2'd2), 0, "R8");
    add_close(1, "R7 (R2)");
    run(20'h2a540, 0, 2'd3, 2'd0, 1, 20'h2a590, 1, 2'd2, 2'd2);
  endtask

  task automatic t_two_close(input bit cont, input logic [19:0] a2, input string tag);
    cfg_cont_page = cont;
    add_open(12'h155, "R3");
    add_cols(8'h08, 0, 2, 0, "R4 (R2)");
    add_close(0, tag);
    add_open(a2[19:8], tag);
    add_cols(a2[7:0], 0, 1, 0, "R4 (R2)");
    add_close(0, "R7 (R2)");
    run(20'h15508, 0, 2'd2, 2'd2, 1, a2, 0, 2'd2, 2'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_single(20'h12310, 0, 2'd2, 2'd0);   // 1 beat read
    t_single(20'h0ff21, 1, 2'd1, 2'd0);   // half on 32-bit, 1 beat write
    t_single(20'h7ff00, 0, 2'd3, 2'd1);   // line on 8-bit, 16 beats
    t_single(20'h80033, 1, 2'd2, 2'd2);   // word on 16-bit, 2 writes
    t_single(20'h00105, 1, 2'd0, 2'd1);   // byte on 8-bit
    t_cont_hit();
    t_two_close(1, 20'h3c612, "R9");
    t_two_close(0, 20'h15520, "R10");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule